// File: doc/BRIEF.md
# Valid-Tracked Multi-Port Scratchpad

A small on-chip word memory with several independent request ports and a valid bit on every word. Used as a plain RAM, every served access succeeds. With gating switched on, the valid bits turn the memory into a handshake buffer between a producer and a consumer. A read can be held back until the word has been filled. A write can be held back until the previous value has been drained. A read can also empty the word it returns, so the same data is never consumed twice.

Each port presents a request with a direction, a word address, write data and byte strobes. One cycle later the port gets a response that says whether the access took effect or must be retried. The number of accesses the array can serve in a cycle is a parameter. When more ports request than there are service slots, the lower-numbered ports win and the others are told to retry. Two ports that hit the same word in one cycle never both succeed: the lower port goes first, and the higher port sees the updated word when it retries.

Top module: `vtrack_spm`

## Requirements
- R1: After reset no response is pending and every word is marked empty, so a gated read that requires a filled word is refused.
- R2: Every request gets exactly one response (`rsp_valid_o` high) in the cycle after it is presented, and a port with no request gets none.
- R3: With `cfg_gate_en` low, every served access succeeds, and a read returns the last value written to that word.
- R4: A write changes only the bytes whose strobe bit is set (strobe bit k covers data bits 8k+7 to 8k). Other bytes keep their old value.
- R5: With `cfg_gate_en` high and `cfg_rd_unset_ok` low, a read of an empty word is refused, and a read of a filled word succeeds.
- R6: With `cfg_gate_en` high and `cfg_wr_need_drain` high, a write to a filled word is refused, and a write to an empty word succeeds and marks the word filled.
- R7: With `cfg_drain_on_rd` high, a successful read returns the stored word, then sets it to zero and marks it empty.
- R8: A refused access changes neither the stored data nor the filled/empty state of any word.
- R9: With two service slots, two ports that address different words are both served in the same cycle.
- R10: When two ports address the same word in one cycle, the lower-numbered port is served and the higher-numbered one is refused. A retry in the next cycle sees the word as the first access left it.
- R11: With one service slot, two requests in the same cycle produce a refusal for the higher-numbered port.
- R12: The read data of a response is zero when the access was a write or was refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_gate_en | input | 1 | Turns on the valid-bit gating rules |
| cfg_rd_unset_ok | input | 1 | When gating, lets reads of empty words succeed |
| cfg_wr_need_drain | input | 1 | When gating, refuses writes to filled words |
| cfg_drain_on_rd | input | 1 | A successful read zeroes the word and marks it empty |
| req_i | input | NPORTS | Request per port |
| we_i | input | NPORTS | 1 = write, 0 = read, per port |
| addr_i | input | NPORTS*log2(DEPTH) | Word address per port, port p in slice p |
| wdata_i | input | NPORTS*DATA_W | Write data per port |
| wstrb_i | input | NPORTS*DATA_W/8 | Byte strobes per port |
| rsp_valid_o | output | NPORTS | Response present, one cycle after the request |
| rsp_ok_o | output | NPORTS | 1 = access took effect, 0 = retry |
| rdata_o | output | NPORTS*DATA_W | Read data per port |

## Verification
A wrong filled/empty bit does not show at once. It shows on the next gated access to that word, as a refusal where success was due, or the reverse. For this reason the stimulus always follows a write, a drain or a refusal with a gated access to the same word in the next cycle. Stale or wrongly merged data shows in the read data of the next successful read, one cycle after that read is presented. Broken arbitration shows in the same response cycle, when both ports succeed on one word or when a slot goes missing.

// File: rtl/vspm_pkg.sv
package vspm_pkg;
  typedef struct packed {
    logic gate_en;
    logic rd_unset_ok;
    logic wr_need_drain;
    logic drain_on_rd;
  } spm_mode_t;
endpackage

// File: rtl/vspm_arb.sv
module vspm_arb #(
  parameter int NPORTS    = 2,
  parameter int SVC_PORTS = 2,
  parameter int AW        = 4
) (
  input  logic [NPORTS-1:0]    req_i,
  input  logic [NPORTS*AW-1:0] addr_i,
  output logic [NPORTS-1:0]    grant_o
);
  always_comb begin
    int  used;
    logic clash;
    used    = 0;
    grant_o = '0;
    for (int i = 0; i < NPORTS; i++) begin
      clash = 1'b0;
      for (int j = 0; j < NPORTS; j++) begin
        if (j < i && grant_o[j] && addr_i[j*AW +: AW] == addr_i[i*AW +: AW])
          clash = 1'b1;
      end
      if (req_i[i] && used < SVC_PORTS && !clash) begin
        grant_o[i] = 1'b1;
        used       = used + 1;
      end
    end
  end
endmodule

// File: rtl/vspm_gate.sv
module vspm_gate #(
  parameter int NPORTS = 2,
  parameter int DEPTH  = 16,
  parameter int AW     = 4
) (
  input  logic [NPORTS-1:0]    grant_i,
  input  logic [NPORTS-1:0]    we_i,
  input  logic [NPORTS*AW-1:0] addr_i,
  input  logic [DEPTH-1:0]     valid_i,
  input  logic                 gate_en_i,
  input  logic                 rd_unset_ok_i,
  input  logic                 wr_need_drain_i,
  output logic [NPORTS-1:0]    ok_o
);
  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic full;
    logic allowed;
    assign full = valid_i[addr_i[p*AW +: AW]];
    always_comb begin
      if (!gate_en_i)    allowed = 1'b1;
      else if (we_i[p])  allowed = !wr_need_drain_i || !full;
      else               allowed = rd_unset_ok_i || full;
    end
    assign ok_o[p] = grant_i[p] && allowed;
  end
endmodule

// File: rtl/vspm_store.sv
module vspm_store #(
  parameter int NPORTS = 2,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int AW     = 4,
  parameter int SW     = DATA_W / 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPORTS-1:0]        req_i,
  input  logic [NPORTS-1:0]        ok_i,
  input  logic [NPORTS-1:0]        we_i,
  input  logic [NPORTS*AW-1:0]     addr_i,
  input  logic [NPORTS*DATA_W-1:0] wdata_i,
  input  logic [NPORTS*SW-1:0]     wstrb_i,
  input  logic                     drain_on_rd_i,
  output logic [DEPTH-1:0]         valid_o,
  output logic [NPORTS-1:0]        rsp_valid_o,
  output logic [NPORTS-1:0]        rsp_ok_o,
  output logic [NPORTS*DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0]        mem_q [DEPTH];
  logic [DATA_W-1:0]        mem_d [DEPTH];
  logic [DEPTH-1:0]         mem_en;
  logic [DEPTH-1:0]         valid_q, valid_d;
  logic [NPORTS-1:0]        rsp_valid_q, rsp_ok_q;
  logic [NPORTS*DATA_W-1:0] rdata_q, rdata_d;

  // next state: granted ports never share a word, so updates do not collide
  always_comb begin
    logic [AW-1:0] a;
    valid_d = valid_q;
    mem_en  = '0;
    rdata_d = '0;
    for (int k = 0; k < DEPTH; k++) mem_d[k] = mem_q[k];
    for (int p = 0; p < NPORTS; p++) begin
      a = addr_i[p*AW +: AW];
      if (ok_i[p]) begin
        if (we_i[p]) begin
          for (int b = 0; b < SW; b++)
            if (wstrb_i[p*SW + b])
              mem_d[a][b*8 +: 8] = wdata_i[p*DATA_W + b*8 +: 8];
          mem_en[a]  = 1'b1;
          valid_d[a] = 1'b1;
        end else begin
          rdata_d[p*DATA_W +: DATA_W] = mem_q[a];
          if (drain_on_rd_i) begin
            mem_d[a]   = '0;
            mem_en[a]  = 1'b1;
            valid_d[a] = 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < DEPTH; k++)
      if (mem_en[k]) mem_q[k] <= mem_d[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q     <= '0;
      rsp_valid_q <= '0;
      rsp_ok_q    <= '0;
      rdata_q     <= '0;
    end else begin
      valid_q     <= valid_d;
      rsp_valid_q <= req_i;
      rsp_ok_q    <= ok_i;
      rdata_q     <= rdata_d;
    end
  end

  assign valid_o     = valid_q;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_ok_o    = rsp_ok_q;
  assign rdata_o     = rdata_q;
endmodule

// File: rtl/vtrack_spm.sv
module vtrack_spm #(
  parameter int NPORTS    = 2,
  parameter int SVC_PORTS = 2,
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 16
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                cfg_gate_en,
  input  logic                                cfg_rd_unset_ok,
  input  logic                                cfg_wr_need_drain,
  input  logic                                cfg_drain_on_rd,
  input  logic [NPORTS-1:0]                   req_i,
  input  logic [NPORTS-1:0]                   we_i,
  input  logic [NPORTS*$clog2(DEPTH)-1:0]     addr_i,
  input  logic [NPORTS*DATA_W-1:0]            wdata_i,
  input  logic [NPORTS*(DATA_W/8)-1:0]        wstrb_i,
  output logic [NPORTS-1:0]                   rsp_valid_o,
  output logic [NPORTS-1:0]                   rsp_ok_o,
  output logic [NPORTS*DATA_W-1:0]            rdata_o
);
  import vspm_pkg::*;
  localparam int AW = $clog2(DEPTH);
  localparam int SW = DATA_W / 8;

  spm_mode_t         mode;
  logic [NPORTS-1:0] grant, ok;
  logic [DEPTH-1:0]  valid;

  assign mode = '{gate_en: cfg_gate_en, rd_unset_ok: cfg_rd_unset_ok,
                  wr_need_drain: cfg_wr_need_drain, drain_on_rd: cfg_drain_on_rd};

  vspm_arb #(.NPORTS(NPORTS), .SVC_PORTS(SVC_PORTS), .AW(AW)) u_arb (
    .req_i(req_i), .addr_i(addr_i), .grant_o(grant)
  );

  vspm_gate #(.NPORTS(NPORTS), .DEPTH(DEPTH), .AW(AW)) u_gate (
    .grant_i(grant), .we_i(we_i), .addr_i(addr_i), .valid_i(valid),
    .gate_en_i(mode.gate_en), .rd_unset_ok_i(mode.rd_unset_ok),
    .wr_need_drain_i(mode.wr_need_drain), .ok_o(ok)
  );

  vspm_store #(.NPORTS(NPORTS), .DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW), .SW(SW)) u_store (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .ok_i(ok), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .wstrb_i(wstrb_i),
    .drain_on_rd_i(mode.drain_on_rd), .valid_o(valid),
    .rsp_valid_o(rsp_valid_o), .rsp_ok_o(rsp_ok_o), .rdata_o(rdata_o)
  );
endmodule

// File: rtl/vtrack_spm_chk.sv
module vtrack_spm_chk #(
  parameter int NPORTS = 2,
  parameter int DATA_W = 32,
  parameter int AW     = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cfg_gate_en,
  input logic [NPORTS-1:0]        req_i,
  input logic [NPORTS*AW-1:0]     addr_i,
  input logic [NPORTS-1:0]        rsp_valid_o,
  input logic [NPORTS-1:0]        rsp_ok_o,
  input logic [NPORTS*DATA_W-1:0] rdata_o
);
  assert_reset_quiet_R1: assert property (@(posedge clk) $rose(rst_n) |-> rsp_valid_o == '0);

  assert_plain_port0_ok_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_gate_en && req_i[0]) |=> rsp_ok_o[0]);

  for (genvar p = 0; p < NPORTS; p++) begin : g_chk
    assert_rsp_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_i[p] |=> rsp_valid_o[p]);
    assert_no_req_no_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i[p] |=> !rsp_valid_o[p]);
    assert_refused_zero_data_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid_o[p] && !rsp_ok_o[p]) |-> rdata_o[p*DATA_W +: DATA_W] == '0);
  end

  if (NPORTS >= 2) begin : g_pair
    assert_same_word_upper_waits_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i[0] && req_i[1] && addr_i[0 +: AW] == addr_i[AW +: AW]) |=> !rsp_ok_o[1]);
  end
endmodule

bind vtrack_spm vtrack_spm_chk #(.NPORTS(NPORTS), .DATA_W(DATA_W), .AW($clog2(DEPTH))) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_gate_en(cfg_gate_en), .req_i(req_i), .addr_i(addr_i),
  .rsp_valid_o(rsp_valid_o), .rsp_ok_o(rsp_ok_o), .rdata_o(rdata_o)
);

// File: tb/tb_vtrack_spm.sv
module tb_vtrack_spm;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        we;
    logic [3:0]  addr;
    logic [31:0] wdata;
    logic [3:0]  strb;
    logic [3:0]  mode;   // {gate, rd_unset_ok, wr_need_drain, drain_on_rd}
    logic        ok;
    logic [31:0] rd;
    logic [7:0]  rtag;
  } vec_t;

  localparam vec_t VECS [16] = '{
    '{1'b1, 4'd1, 32'h11223344, 4'hF, 4'b0000, 1'b1, 32'h0,        8'd3},  // R3 write
    '{1'b0, 4'd1, 32'h0,        4'h0, 4'b0000, 1'b1, 32'h11223344, 8'd3},  // R3 read back
    '{1'b1, 4'd1, 32'hAABBCCDD, 4'h5, 4'b0000, 1'b1, 32'h0,        8'd4},  // R4 bytes 0,2
    '{1'b0, 4'd1, 32'h0,        4'h0, 4'b0000, 1'b1, 32'h11BB33DD, 8'd4},  // R4 merge
    '{1'b0, 4'd5, 32'h0,        4'h0, 4'b1000, 1'b0, 32'h0,        8'd5},  // R5 empty read
    '{1'b1, 4'd5, 32'h00000055, 4'hF, 4'b1000, 1'b1, 32'h0,        8'd5},  // R5 fill
    '{1'b0, 4'd5, 32'h0,        4'h0, 4'b1000, 1'b1, 32'h00000055, 8'd5},  // R5 filled read
    '{1'b1, 4'd5, 32'h00000066, 4'hF, 4'b1010, 1'b0, 32'h0,        8'd6},  // R6 refused
    '{1'b0, 4'd5, 32'h0,        4'h0, 4'b1000, 1'b1, 32'h00000055, 8'd8},  // R8 unchanged
    '{1'b0, 4'd5, 32'h0,        4'h0, 4'b1001, 1'b1, 32'h00000055, 8'd7},  // R7 drain
    '{1'b0, 4'd5, 32'h0,        4'h0, 4'b1000, 1'b0, 32'h0,        8'd7},  // R7 now empty
    '{1'b1, 4'd5, 32'h00000077, 4'hF, 4'b1010, 1'b1, 32'h0,        8'd6},  // R6 empty write
    '{1'b0, 4'd5, 32'h0,        4'h0, 4'b0000, 1'b1, 32'h00000077, 8'd3},  // R3
    '{1'b0, 4'd5, 32'h0,        4'h0, 4'b0001, 1'b1, 32'h00000077, 8'd7},  // R7 plain drain
    '{1'b0, 4'd5, 32'h0,        4'h0, 4'b0000, 1'b1, 32'h0,        8'd7},  // R7 zeroed
    '{1'b0, 4'd5, 32'h0,        4'h0, 4'b1100, 1'b1, 32'h0,        8'd5}   // R5 unset ok
  };

  logic        clk, rst_n;
  logic        g_en, rd_ok, wr_dr, dr_rd;
  logic [1:0]  req, we;
  logic [7:0]  addr;
  logic [63:0] wdata;
  logic [7:0]  wstrb;
  logic [1:0]  rv, rok, rv1, rok1;
  logic [63:0] rdat, rdat1;
  int nchk = 0, nerr = 0;
  bit done = 0;

  vtrack_spm #(.NPORTS(2), .SVC_PORTS(2), .DATA_W(32), .DEPTH(16)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_gate_en(g_en), .cfg_rd_unset_ok(rd_ok),
    .cfg_wr_need_drain(wr_dr), .cfg_drain_on_rd(dr_rd), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .wstrb_i(wstrb),
    .rsp_valid_o(rv), .rsp_ok_o(rok), .rdata_o(rdat));

  vtrack_spm #(.NPORTS(2), .SVC_PORTS(1), .DATA_W(32), .DEPTH(16)) dut_one_slot (
    .clk(clk), .rst_n(rst_n), .cfg_gate_en(g_en), .cfg_rd_unset_ok(rd_ok),
    .cfg_wr_need_drain(wr_dr), .cfg_drain_on_rd(dr_rd), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .wstrb_i(wstrb),
    .rsp_valid_o(rv1), .rsp_ok_o(rok1), .rdata_o(rdat1));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_mode(input logic [3:0] m);
    {g_en, rd_ok, wr_dr, dr_rd} = m;
  endtask

  task automatic drv(input int p, input logic w, input logic [3:0] a,
                     input logic [31:0] d, input logic [3:0] s);
    req[p] = 1'b1; we[p] = w; addr[p*4 +: 4] = a;
    wdata[p*32 +: 32] = d; wstrb[p*4 +: 4] = s;
  endtask

  task automatic idle();
    req = '0; we = '0; addr = '0; wdata = '0; wstrb = '0;
  endtask

  // drive on the falling edge, sample one step after the rising edge
  task automatic step();
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; idle(); set_mode(4'b0000);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    chk("R1 no response after reset", {30'd0, rv}, 32'd0);
    step();
    chk("R2 idle gives no response", {30'd0, rv}, 32'd0);

    // table walk, port 0 only
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); idle(); set_mode(VECS[i].mode);
      drv(0, VECS[i].we, VECS[i].addr, VECS[i].wdata, VECS[i].strb);
      step();
      chk($sformatf("R%0d vec %0d rsp_valid", VECS[i].rtag, i), {31'd0, rv[0]}, 32'd1);
      chk($sformatf("R%0d vec %0d ok", VECS[i].rtag, i), {31'd0, rok[0]}, {31'd0, VECS[i].ok});
      chk($sformatf("R%0d vec %0d rdata", VECS[i].rtag, i), rdat[31:0], VECS[i].rd);
    end

    // R9: two different words in one cycle
    @(negedge clk); idle(); set_mode(4'b1010);
    drv(0, 1'b1, 4'd2, 32'hC0DE0002, 4'hF); drv(1, 1'b1, 4'd3, 32'hC0DE0003, 4'hF);
    step();
    chk("R9 both writes served", {30'd0, rok}, 32'd3);
    @(negedge clk); idle(); set_mode(4'b1000);
    drv(0, 1'b0, 4'd2, 32'h0, 4'h0); drv(1, 1'b0, 4'd3, 32'h0, 4'h0);
    step();
    chk("R9 both reads served", {30'd0, rok}, 32'd3);
    chk("R9 port0 data", rdat[31:0], 32'hC0DE0002);
    chk("R9 port1 data", rdat[63:32], 32'hC0DE0003);

    // R10: same word, lower port wins, upper retries
    @(negedge clk); idle(); set_mode(4'b1100);
    drv(0, 1'b1, 4'd7, 32'h00000070, 4'hF); drv(1, 1'b1, 4'd7, 32'h00000071, 4'hF);
    step();
    chk("R10 port0 served", {31'd0, rok[0]}, 32'd1);
    chk("R10 port1 refused", {31'd0, rok[1]}, 32'd0);
    @(negedge clk); idle(); drv(1, 1'b0, 4'd7, 32'h0, 4'h0);
    step();
    chk("R10 retry sees port0 value", rdat[63:32], 32'h00000070);
    chk("R10 retry ok", {31'd0, rok[1]}, 32'd1);

    // R11: single service slot refuses the upper port
    @(negedge clk); idle(); set_mode(4'b0000);
    drv(0, 1'b1, 4'd10, 32'hA, 4'hF); drv(1, 1'b1, 4'd11, 32'hB, 4'hF);
    step();
    chk("R11 one slot: port0 ok, port1 retry", {30'd0, rok1}, 32'd1);
    chk("R11 one slot: both answered", {30'd0, rv1}, 32'd3);
    chk("R9 two slots: both ok", {30'd0, rok}, 32'd3);
    @(negedge clk); idle();
    step();
    chk("R2 no request no response", {28'd0, rv1, rv}, 32'd0);

    // R1: reset mid-run empties every word
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; set_mode(4'b1000);
    drv(0, 1'b0, 4'd2, 32'h0, 4'h0);
    step();
    chk("R1 word empty after reset", {31'd0, rok[0]}, 32'd0);
    chk("R12 refused read data zero", rdat[31:0], 32'd0);
    @(negedge clk); idle();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule